// File: doc/BRIEF.md
# Relative Branch and Loop Unit

This unit resolves control transfers for a byte-addressed processor pipeline. For each valid branch operation it decides whether control is redirected, and produces the address the fetch stage continues from. Three kinds of operation are handled: a conditional jump that tests the flags left by the latest data-manipulation result, a counted loop that steps a counter register down and branches while it is still nonzero, and an unconditional jump.

A branch target is always formed relative to the address that follows the branch instruction. The displacement is either a single signed byte or a full signed 32-bit word. The caller supplies that sequential address, the raw displacement, and a size bit. All results are registered, so they appear one clock after the inputs. The counter result comes with a write strobe for the register file. Flags are only read; no operation here changes them.

Top module: `bw_branch_unit`

## Requirements
- R1: The taken target is the sequential address plus the sign-extended displacement, modulo 2^AW. When `long_i` is 0, only `rel_off_i[7:0]` is used, sign-extended; when it is 1, all 32 bits are used. Example: sequential 1007 with byte 0xF9 gives 1000.
- R2: When a valid operation is not taken, including op code 3 (idle), `next_addr_o` equals the sequential address.
- R3: Conditional jump (op 0) is taken by `cond_i` as follows: 0 zero set; 1 zero clear; 2 greater (zero clear and sign equal to overflow); 3 not greater; 4 sign set; 5 sign clear; 6 carry set; 7 carry clear.
- R4: Loop (op 1) outputs `count_i - 1`, wrapping modulo 2^CW, with `count_we_o` high. It is taken exactly when that result is nonzero. The flag inputs have no effect on it.
- R5: Unconditional jump (op 2) is always taken, with either displacement size.
- R6: `count_we_o` is high only for a valid loop operation.
- R7: With `valid_i` low, the next cycle shows `valid_o`, `taken_o` and `count_we_o` low.
- R8: While reset is asserted (active low), every output is zero.
- R9: Outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 2 | 0 conditional, 1 loop, 2 jump, 3 idle |
| cond_i | input | 3 | Condition selector (see R3) |
| long_i | input | 1 | 1: 32-bit displacement, 0: 8-bit |
| seq_addr_i | input | AW | Address after the branch instruction |
| rel_off_i | input | 32 | Raw signed displacement |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| flag_s_i | input | 1 | Sign flag |
| flag_o_i | input | 1 | Overflow flag |
| count_i | input | CW | Current counter register value |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch redirected control |
| next_addr_o | output | AW | Address to continue fetching from |
| count_o | output | CW | Counter value to write back |
| count_we_o | output | 1 | Counter write strobe |

## Verification
The sweep covers every operation, all eight condition codes, all sixteen flag combinations, and both displacement sizes. This separates condition decoding errors from flag-ordering errors, and sign-extension errors from size-select errors. Loop vectors use counts of 0, 1, 2 and a mid-range value. These distinguish the fall-through at one from the wrap at zero, and show that the flags are ignored. Directed vectors add a short backward branch, a long forward branch that wraps past the top of the address space, and a valid-low cycle.

// File: rtl/bw_pkg.sv
package bw_pkg;

    typedef enum logic [1:0] {
        BR_COND = 2'd0,
        BR_LOOP = 2'd1,
        BR_JUMP = 2'd2,
        BR_IDLE = 2'd3
    } br_op_e;

    typedef enum logic [2:0] {
        CC_ZERO    = 3'd0,
        CC_NZERO   = 3'd1,
        CC_GREATER = 3'd2,
        CC_NGREAT  = 3'd3,
        CC_NEG     = 3'd4,
        CC_NNEG    = 3'd5,
        CC_CARRY   = 3'd6,
        CC_NCARRY  = 3'd7
    } cc_sel_e;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic o;
    } flags_t;

    localparam int SHORT_W = 8;
    localparam int LONG_W  = 32;

endpackage

// File: rtl/bw_offset_ext.sv
module bw_offset_ext #(
    parameter int AW = 32
) (
    input  logic [bw_pkg::LONG_W-1:0] raw_i,
    input  logic                      long_i,
    output logic [AW-1:0]             ext_o
);
    logic signed [bw_pkg::SHORT_W-1:0] short_s;
    logic signed [bw_pkg::LONG_W-1:0]  long_s;

    always_comb begin
        short_s = raw_i[bw_pkg::SHORT_W-1:0];
        long_s  = raw_i;
        if (long_i) begin
            ext_o = AW'(long_s);
        end else begin
            ext_o = AW'(short_s);
        end
    end
endmodule

// File: rtl/bw_cond_eval.sv
module bw_cond_eval
    import bw_pkg::*;
(
    input  cc_sel_e sel_i,
    input  flags_t  flags_i,
    output logic    pass_o
);
    logic greater;

    always_comb begin
        greater = !flags_i.z && (flags_i.s == flags_i.o);
        case (sel_i)
            CC_ZERO:    pass_o = flags_i.z;
            CC_NZERO:   pass_o = !flags_i.z;
            CC_GREATER: pass_o = greater;
            CC_NGREAT:  pass_o = !greater;
            CC_NEG:     pass_o = flags_i.s;
            CC_NNEG:    pass_o = !flags_i.s;
            CC_CARRY:   pass_o = flags_i.c;
            CC_NCARRY:  pass_o = !flags_i.c;
            default:    pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bw_loop_ctr.sv
module bw_loop_ctr #(
    parameter int CW = 32
) (
    input  logic [CW-1:0] count_i,
    output logic [CW-1:0] dec_o,
    output logic          nonzero_o
);
    always_comb begin
        dec_o     = count_i - CW'(1);
        nonzero_o = |dec_o;
    end
endmodule

// File: rtl/bw_branch_unit.sv
module bw_branch_unit
    import bw_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [1:0]        op_i,
    input  logic [2:0]        cond_i,
    input  logic              long_i,
    input  logic [AW-1:0]     seq_addr_i,
    input  logic [LONG_W-1:0] rel_off_i,
    input  logic              flag_c_i,
    input  logic              flag_z_i,
    input  logic              flag_s_i,
    input  logic              flag_o_i,
    input  logic [CW-1:0]     count_i,
    output logic              valid_o,
    output logic              taken_o,
    output logic [AW-1:0]     next_addr_o,
    output logic [CW-1:0]     count_o,
    output logic              count_we_o
);
    typedef struct packed {
        logic          valid;
        logic          taken;
        logic [AW-1:0] next_addr;
        logic [CW-1:0] count;
        logic          count_we;
    } res_t;

    res_t    res_d, res_q;
    br_op_e  op;
    flags_t  flags;
    logic [AW-1:0] off_ext;
    logic [AW-1:0] target;
    logic          cond_pass;
    logic [CW-1:0] count_dec;
    logic          count_nz;
    logic          take;

    assign op    = br_op_e'(op_i);
    assign flags = '{c: flag_c_i, z: flag_z_i, s: flag_s_i, o: flag_o_i};

    bw_offset_ext #(.AW(AW)) u_ext (
        .raw_i  (rel_off_i),
        .long_i (long_i),
        .ext_o  (off_ext)
    );

    bw_cond_eval u_cond (
        .sel_i   (cc_sel_e'(cond_i)),
        .flags_i (flags),
        .pass_o  (cond_pass)
    );

    bw_loop_ctr #(.CW(CW)) u_ctr (
        .count_i   (count_i),
        .dec_o     (count_dec),
        .nonzero_o (count_nz)
    );

    assign target = seq_addr_i + off_ext;

    always_comb begin
        res_d           = '0;
        res_d.next_addr = seq_addr_i;
        res_d.count     = count_i;
        take            = 1'b0;
        if (valid_i) begin
            res_d.valid = 1'b1;
            case (op)
                BR_COND: take = cond_pass;
                BR_LOOP: begin
                    take           = count_nz;
                    res_d.count    = count_dec;
                    res_d.count_we = 1'b1;
                end
                BR_JUMP: take = 1'b1;
                default: take = 1'b0;
            endcase
            res_d.taken = take;
            if (take) begin
                res_d.next_addr = target;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign valid_o     = res_q.valid;
    assign taken_o     = res_q.taken;
    assign next_addr_o = res_q.next_addr;
    assign count_o     = res_q.count;
    assign count_we_o  = res_q.count_we;
endmodule

// File: rtl/bw_branch_chk.sv
module bw_branch_chk #(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_i,
    input logic [1:0]    op_i,
    input logic [AW-1:0] seq_addr_i,
    input logic [CW-1:0] count_i,
    input logic          valid_o,
    input logic          taken_o,
    input logic [AW-1:0] next_addr_o,
    input logic [CW-1:0] count_o,
    input logic          count_we_o
);
    AST_TAKEN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o || count_we_o) |-> valid_o); // R7

    AST_FALLTHROUGH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !taken_o) |-> next_addr_o == $past(seq_addr_i)); // R2

    AST_WE_ONLY_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        count_we_o |-> $past(valid_i && op_i == 2'd1)); // R6

    AST_LOOP_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        count_we_o |-> count_o == $past(count_i) - CW'(1)); // R4

    AST_LOOP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        count_we_o |-> taken_o == (count_o != '0)); // R4

    AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(op_i == 2'd2)) |-> taken_o); // R5
endmodule

bind bw_branch_unit bw_branch_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .op_i        (op_i),
    .seq_addr_i  (seq_addr_i),
    .count_i     (count_i),
    .valid_o     (valid_o),
    .taken_o     (taken_o),
    .next_addr_o (next_addr_o),
    .count_o     (count_o),
    .count_we_o  (count_we_o)
);

// File: tb/bw_branch_unit_bench.sv
module bw_branch_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [1:0]    op_i = '0;
    logic [2:0]    cond_i = '0;
    logic          long_i = 1'b0;
    logic [AW-1:0] seq_addr_i = '0;
    logic [31:0]   rel_off_i = '0;
    logic          flag_c_i = 1'b0, flag_z_i = 1'b0, flag_s_i = 1'b0, flag_o_i = 1'b0;
    logic [CW-1:0] count_i = '0;
    logic          valid_o, taken_o, count_we_o;
    logic [AW-1:0] next_addr_o;
    logic [CW-1:0] count_o;

    int n_vec = 0;
    int n_bad = 0;

    bw_branch_unit #(.AW(AW), .CW(CW)) u_bw_branch_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .cond_i(cond_i),
        .long_i(long_i), .seq_addr_i(seq_addr_i), .rel_off_i(rel_off_i),
        .flag_c_i(flag_c_i), .flag_z_i(flag_z_i), .flag_s_i(flag_s_i), .flag_o_i(flag_o_i),
        .count_i(count_i), .valid_o(valid_o), .taken_o(taken_o),
        .next_addr_o(next_addr_o), .count_o(count_o), .count_we_o(count_we_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    function automatic logic cond_ok(input logic [2:0] sel, input logic [3:0] fl);
        logic c, z, s, o, gt;
        c = fl[0]; z = fl[1]; s = fl[2]; o = fl[3];
        gt = (z == 1'b0) && (s == o);
        case (sel)
            3'd0: return z;
            3'd1: return !z;
            3'd2: return gt;
            3'd3: return !gt;
            3'd4: return s;
            3'd5: return !s;
            3'd6: return c;
            default: return !c;
        endcase
    endfunction

    task automatic run_vec(input logic vld, input logic [1:0] op, input logic [2:0] sel,
                           input logic [3:0] fl, input logic lg, input logic [31:0] seq,
                           input logic [31:0] off, input logic [31:0] cnt, input string req);
        longint disp;
        logic [31:0] tgt, e_cnt, e_addr;
        logic e_tk, e_we;
        @(negedge clk);
        valid_i = vld; op_i = op; cond_i = sel; long_i = lg; seq_addr_i = seq;
        rel_off_i = off; count_i = cnt;
        flag_c_i = fl[0]; flag_z_i = fl[1]; flag_s_i = fl[2]; flag_o_i = fl[3];
        // R1: displacement value as a signed number, added modulo 2^32
        if (lg) disp = longint'(off) - ((off[31]) ? 64'sd4294967296 : 64'sd0);
        else    disp = longint'(off[7:0]) - ((off[7]) ? 64'sd256 : 64'sd0);
        tgt   = 32'(longint'(seq) + disp);
        e_cnt = cnt;
        e_we  = 1'b0;
        case (op)
            2'd0: e_tk = cond_ok(sel, fl);
            2'd1: begin e_cnt = 32'(longint'(cnt) - 1); e_we = 1'b1; e_tk = (e_cnt != 0); end
            2'd2: e_tk = 1'b1;
            default: e_tk = 1'b0;
        endcase
        if (!vld) begin e_tk = 1'b0; e_we = 1'b0; end
        e_addr = e_tk ? tgt : seq;
        @(negedge clk);
        n_vec++;
        if (!vld) begin
            if (valid_o || taken_o || count_we_o) begin
                n_bad++;
                $display("FAIL %s: v/t/we actual %b%b%b expected 000", req, valid_o, taken_o, count_we_o);
            end
        end else if (valid_o !== 1'b1 || taken_o !== e_tk || next_addr_o !== e_addr ||
                     count_we_o !== e_we || (e_we && count_o !== e_cnt)) begin
            n_bad++;
            $display("FAIL %s: op%0d cc%0d fl%h lg%0d actual t=%b a=%h we=%b c=%h expected t=%b a=%h we=%b c=%h",
                     req, op, sel, fl, lg, taken_o, next_addr_o, count_we_o, count_o,
                     e_tk, e_addr, e_we, e_cnt);
        end
    endtask

    initial begin
        logic [31:0] cnts [4];
        string req;
        cnts[0] = 32'd0; cnts[1] = 32'd1; cnts[2] = 32'd2; cnts[3] = 32'h8000_0000;
        repeat (3) @(negedge clk);
        // R8: reset state
        n_vec++;
        if (valid_o !== 1'b0 || taken_o !== 1'b0 || count_we_o !== 1'b0 ||
            next_addr_o !== '0 || count_o !== '0) begin
            n_bad++;
            $display("FAIL R8: reset outputs actual %b%b%b %h %h expected all zero",
                     valid_o, taken_o, count_we_o, next_addr_o, count_o);
        end
        rst_n = 1'b1;

        // R1: worked example, backward short branch 1007 -> 1000
        run_vec(1'b1, 2'd2, 3'd0, 4'h0, 1'b0, 32'd1007, 32'h0000_00F9, 32'd5, "R1");
        // R1: long forward branch wrapping past the top of the space
        run_vec(1'b1, 2'd2, 3'd0, 4'h0, 1'b1, 32'hFFFF_FFF0, 32'h0000_0020, 32'd5, "R1");
        // R1: short form ignores upper displacement bits
        run_vec(1'b1, 2'd2, 3'd0, 4'h0, 1'b0, 32'h0000_2000, 32'h1234_567F, 32'd5, "R1");
        // R7: idle cycle with valid low
        run_vec(1'b0, 2'd1, 3'd0, 4'h0, 1'b0, 32'h0000_3000, 32'h10, 32'd3, "R7");

        // R2 R3 R4 R5 R6 R9: full sweep
        for (int op = 0; op < 4; op++)
            for (int sel = 0; sel < 8; sel++)
                for (int fl = 0; fl < 16; fl++)
                    for (int lg = 0; lg < 2; lg++) begin
                        case (op)
                            0: req = "R3";
                            1: req = "R4";
                            2: req = "R5";
                            default: req = "R2";
                        endcase
                        run_vec(1'b1, 2'(op), 3'(sel), 4'(fl), 1'(lg),
                                32'h0001_0000 + 32'(fl * 36 + sel * 5),
                                lg ? 32'hFFF0_0000 + 32'(sel * 4099 + fl) : 32'(8'h70 + sel * 29 + fl),
                                cnts[fl % 4], req);
                    end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule